// File: doc/BRIEF.md
# Seconds Counter with Alarm and Event Interrupt

This peripheral keeps wall time as a plain 32-bit count of seconds. A slow reference pulse (`tick_en`) is divided by a parameterised prescaler, and each full division advances the counter while counting is switched on. An alarm compare register raises an alarm event when the counter steps onto its value. A per-second event is also kept. Each event has its own interrupt enable, and both feed one level interrupt output. A scratch register, a regulator trim register and a sticky power-down request complete the register set.

Software reaches the block over a simple 32-bit register bus. Reads return data in the same cycle. Each write is captured and then committed a fixed number of cycles later. While a write is in flight, the ready bit in the control register stays low, and any further write is dropped. Event flags in the control register are cleared by writing 0 to them. Writing 1 leaves them as they are, so a read-modify-write of the control bits cannot lose a pending event.

Top module: `secclk_periph`

## Requirements
- R1: Registers decode at byte offsets 0x00 control, 0x04 seconds, 0x08 alarm, 0x0C regulator trim, 0x20 power-down request, 0x34 scratch. `bus_rdata` shows the addressed register combinationally. Any other offset reads as 0.
- R2: Control register layout: bit 7 ready (read-only), bit 6 second flag, bit 5 second interrupt enable, bit 4 alarm flag, bit 3 alarm interrupt enable, bit 2 alarm enable, bit 0 count enable. All other bits read 0. After reset the control register reads 0x80.
- R3: A write (`bus_sel` and `bus_wr` high at a clock edge) is accepted only while ready is 1. Ready then reads 0 for exactly 4 cycles. The written value becomes visible at the edge where ready returns to 1.
- R4: Writing 0 to bit 6 or bit 4 of the control register clears that flag, and writing 1 leaves it unchanged. If a flag is set and cleared at the same edge, the set wins.
- R5: `irq` is high exactly while (second flag and its enable) or (alarm flag and its enable).
- R6: Committing a power-down write with bit 0 = 1 sets `hib_req`, which stays set until reset. Writing bit 0 = 0 has no effect. Offset 0x20 reads `hib_req` in bit 0.
- R7: Scratch and regulator trim registers hold any 32-bit value written to them and reset to 0.
- R8: A committed seconds write loads the counter and clears the prescaler. No increment happens at that edge.
- R9: With count enable set, every TICK_DIV-th `tick_en` pulse adds 1 to the counter and sets the second flag. With count enable clear, neither the prescaler nor the counter moves.
- R10: When alarm enable is set and an increment makes the counter equal to the alarm register, the alarm flag is set.
- R11: A write presented while ready is 0 is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow reference pulse, one cycle per reference period |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt |
| hib_req | output | 1 | Sticky power-down request |

## Verification
The assertions check four things on every cycle: that an accepted write drops ready at once, that a pending write cannot be disturbed while busy, that flags survive any cycle without a commit, and that scratch and sticky power-down state do not drift. They also check that an uncommitted tick steps the counter by exactly one and that a rising alarm flag coincides with a counter/alarm match. The interplay of commit timing with ticks, flag clearing against simultaneous setting, prescaler reset on a seconds load and the end-to-end interrupt level can only be shown by the bench's reference model, which predicts every read value and output in every cycle across the scenarios.

// File: rtl/secclk_pkg.sv
package secclk_pkg;
    localparam int DW     = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SECS    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ALARM   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIM    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_PWRDN   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 6'h34;

    localparam int BIT_RDY = 7;
    localparam int BIT_SF  = 6;
    localparam int BIT_SIE = 5;
    localparam int BIT_AF  = 4;
    localparam int BIT_AIE = 3;
    localparam int BIT_AEN = 2;
    localparam int BIT_EN  = 0;

    typedef struct packed {
        logic sf;
        logic sie;
        logic af;
        logic aie;
        logic aen;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
    } wreq_t;
endpackage

// File: rtl/secclk_prescale.sv
module secclk_prescale #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic clr,
    output logic sec_tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        sec_tick = run && tick_en && (st_q.cnt == LAST);
        st_d     = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run && tick_en) begin
            st_d.cnt = sec_tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(st_q.cnt)); // R9
endmodule

// File: rtl/secclk_wrgate.sv
module secclk_wrgate
    import secclk_pkg::*;
#(
    parameter int COMMIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_data,
    output logic              ready,
    output logic              cmt_valid,
    output wreq_t             cmt
);
    localparam int BW = $clog2(COMMIT_CYC + 1);
    localparam logic [BW-1:0] START = BW'(COMMIT_CYC);
    localparam logic [BW-1:0] ONE   = BW'(1);

    typedef struct packed {
        logic [BW-1:0] busy;
        wreq_t         pend;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        ready     = (st_q.busy == '0);
        cmt_valid = (st_q.busy == ONE);
        cmt       = st_q.pend;
        st_d      = st_q;
        if (!ready) begin
            st_d.busy = st_q.busy - 1'b1;
        end else if (req) begin
            st_d.busy      = START;
            st_d.pend.addr = req_addr;
            st_d.pend.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready); // R3
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(st_q.pend)); // R11
endmodule

// File: rtl/secclk_regfile.sv
module secclk_regfile
    import secclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmt_valid,
    input  wreq_t             cmt,
    input  logic              sec_tick,
    input  logic              ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rdata,
    output logic              run,
    output logic              secs_clr,
    output logic              irq,
    output logic              hib_req
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] secs;
        logic [DW-1:0] alarm;
        logic [DW-1:0] trim;
        logic [DW-1:0] scratch;
        logic          hib;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_ctrl, wr_secs, wr_alarm, wr_trim, wr_pwrdn, wr_scratch;
    logic    step;
    logic [DW-1:0] secs_inc;

    always_comb begin
        wr_ctrl    = cmt_valid && (cmt.addr == OFS_CTRL);
        wr_secs    = cmt_valid && (cmt.addr == OFS_SECS);
        wr_alarm   = cmt_valid && (cmt.addr == OFS_ALARM);
        wr_trim    = cmt_valid && (cmt.addr == OFS_TRIM);
        wr_pwrdn   = cmt_valid && (cmt.addr == OFS_PWRDN);
        wr_scratch = cmt_valid && (cmt.addr == OFS_SCRATCH);
        step       = sec_tick && !wr_secs;
        secs_inc   = st_q.secs + 1'b1;
        secs_clr   = wr_secs;
        run        = st_q.ctrl.en;
        hib_req    = st_q.hib;
        irq        = (st_q.ctrl.sf && st_q.ctrl.sie) || (st_q.ctrl.af && st_q.ctrl.aie);
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.en  = cmt.data[BIT_EN];
            st_d.ctrl.aen = cmt.data[BIT_AEN];
            st_d.ctrl.aie = cmt.data[BIT_AIE];
            st_d.ctrl.sie = cmt.data[BIT_SIE];
            st_d.ctrl.sf  = st_q.ctrl.sf && cmt.data[BIT_SF];
            st_d.ctrl.af  = st_q.ctrl.af && cmt.data[BIT_AF];
        end
        if (wr_secs) begin
            st_d.secs = cmt.data;
        end else if (step) begin
            st_d.secs = secs_inc;
        end
        if (step) begin
            st_d.ctrl.sf = 1'b1;
            if (st_q.ctrl.aen && (secs_inc == st_q.alarm)) begin
                st_d.ctrl.af = 1'b1;
            end
        end
        if (wr_alarm)   st_d.alarm   = cmt.data;
        if (wr_trim)    st_d.trim    = cmt.data;
        if (wr_scratch) st_d.scratch = cmt.data;
        if (wr_pwrdn && cmt.data[0]) st_d.hib = 1'b1;
    end

    always_comb begin
        rdata = '0;
        case (rd_addr)
            OFS_CTRL: begin
                rdata[BIT_RDY] = ready;
                rdata[BIT_SF]  = st_q.ctrl.sf;
                rdata[BIT_SIE] = st_q.ctrl.sie;
                rdata[BIT_AF]  = st_q.ctrl.af;
                rdata[BIT_AIE] = st_q.ctrl.aie;
                rdata[BIT_AEN] = st_q.ctrl.aen;
                rdata[BIT_EN]  = st_q.ctrl.en;
            end
            OFS_SECS:    rdata = st_q.secs;
            OFS_ALARM:   rdata = st_q.alarm;
            OFS_TRIM:    rdata = st_q.trim;
            OFS_PWRDN:   rdata[0] = st_q.hib;
            OFS_SCRATCH: rdata = st_q.scratch;
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FLAG_HOLD_SF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.sf && !cmt_valid) |=> st_q.ctrl.sf); // R4
    AST_FLAG_HOLD_AF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.af && !cmt_valid) |=> st_q.ctrl.af); // R4
    AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_valid |=> ($stable(st_q.scratch) && $stable(st_q.trim))); // R7
    AST_SECS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !cmt_valid) |=> (st_q.secs == $past(st_q.secs) + 32'd1)); // R9
    AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.ctrl.af) && !$past(cmt_valid)) |-> (st_q.secs == st_q.alarm)); // R10
    AST_HIB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hib |=> st_q.hib); // R6
endmodule

// File: rtl/secclk_periph.sv
module secclk_periph
    import secclk_pkg::*;
#(
    parameter int TICK_DIV   = 32768,
    parameter int COMMIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              hib_req
);
    logic  ready, cmt_valid, sec_tick, run, secs_clr, wr_req;
    wreq_t cmt;

    assign wr_req = bus_sel && bus_wr;

    secclk_wrgate #(.COMMIT_CYC(COMMIT_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .req_addr(bus_addr),
        .req_data(bus_wdata), .ready(ready), .cmt_valid(cmt_valid), .cmt(cmt)
    );

    secclk_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
        .clr(secs_clr), .sec_tick(sec_tick)
    );

    secclk_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt(cmt),
        .sec_tick(sec_tick), .ready(ready), .rd_addr(bus_addr),
        .rdata(bus_rdata), .run(run), .secs_clr(secs_clr),
        .irq(irq), .hib_req(hib_req)
    );

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmt_valid || sec_tick)); // R5
endmodule

// File: tb/sim_secclk_periph.sv
module sim_secclk_periph;
    localparam int DIV = 4;
    localparam int CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, hib_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit tick_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    secclk_periph #(.TICK_DIV(DIV), .COMMIT_CYC(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .hib_req(hib_req)
    );

    // behavioural reference model
    int          m_busy = 0;
    int          m_pre = 0;
    logic [5:0]  m_paddr = '0;
    logic [31:0] m_pdata = '0;
    logic [31:0] m_secs = '0, m_alarm = '0, m_trim = '0, m_scr = '0;
    bit m_sf = 0, m_sie = 0, m_af = 0, m_aie = 0, m_aen = 0, m_en = 0, m_hib = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pre = 0; m_secs = '0; m_alarm = '0; m_trim = '0; m_scr = '0;
            m_sf = 0; m_sie = 0; m_af = 0; m_aie = 0; m_aen = 0; m_en = 0; m_hib = 0;
        end else begin
            bit commit, tick, ldsec, old_aen, old_sf, old_af;
            logic [31:0] old_secs;
            commit   = (m_busy == 1);
            tick     = tick_en && m_en && (m_pre == DIV - 1);
            ldsec    = commit && (m_paddr == 6'h04);
            old_aen  = m_aen;
            old_sf   = m_sf;
            old_af   = m_af;
            old_secs = m_secs;
            if (ldsec) m_pre = 0;
            else if (tick_en && m_en) m_pre = tick ? 0 : m_pre + 1;
            if (commit) begin
                case (m_paddr)
                    6'h00: begin
                        m_en = m_pdata[0]; m_aen = m_pdata[2]; m_aie = m_pdata[3];
                        m_sie = m_pdata[5];
                        m_sf = old_sf && m_pdata[6];
                        m_af = old_af && m_pdata[4];
                    end
                    6'h04: m_secs = m_pdata;
                    6'h08: m_alarm = m_pdata;
                    6'h0C: m_trim = m_pdata;
                    6'h20: if (m_pdata[0]) m_hib = 1;
                    6'h34: m_scr = m_pdata;
                    default: ;
                endcase
            end
            if (tick && !ldsec) begin
                m_secs = old_secs + 1;
                m_sf = 1;
                if (old_aen && (old_secs + 1 == m_alarm_prev())) m_af = 1;
            end
            if (m_busy > 0) m_busy = m_busy - 1;
            else if (bus_sel && bus_wr) begin
                m_busy = CYC; m_paddr = bus_addr; m_pdata = bus_wdata;
            end
        end
    end

    // alarm value before this edge's commit
    logic [31:0] m_alarm_q = '0;
    always @(negedge clk) m_alarm_q = m_alarm;
    function automatic logic [31:0] m_alarm_prev();
        return m_alarm_q;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00: return {24'h0, (m_busy == 0), m_sf, m_sie, m_af, m_aie, m_aen, 1'b0, m_en};
            6'h04: return m_secs;
            6'h08: return m_alarm;
            6'h0C: return m_trim;
            6'h20: return {31'h0, m_hib};
            6'h34: return m_scr;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00: return "R2";
            6'h04: return "R9";
            6'h08: return "R10";
            6'h0C: return "R7";
            6'h20: return "R6";
            6'h34: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (rst_n) begin
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
            chk("R5", {31'h0, irq}, {31'h0, (m_sf && m_sie) || (m_af && m_aie)});
            chk("R6", {31'h0, hib_req}, {31'h0, m_hib});
        end
        tick_en = tick_on && (cyc % 3 != 2);
    endtask

    task automatic wait_ready();
        bus_sel = 0; bus_wr = 0; bus_addr = 6'h00;
        for (int i = 0; i < 20; i++) begin
            step();
            if (bus_rdata[7]) break;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wait_ready();
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 0; bus_wr = 0; bus_addr = a;
        step();
        d = bus_rdata;
    endtask

    task automatic settle();
        wait_ready();
        step();
    endtask

    initial begin
        logic [31:0] v, s;
        step(); step();
        rst_n = 1'b1;
        step();
        rd(6'h00, v); chk("R2 reset ctrl", v, 32'h80);
        rd(6'h34, v); chk("R7 reset scratch", v, 32'h0);
        rd(6'h04, v); chk("R8 reset secs", v, 32'h0);

        // commit timing
        wr(6'h34, 32'hA5A5_1234);
        bus_addr = 6'h00;
        for (int i = 0; i < CYC; i++) begin
            chk("R3 ready low", {31'h0, bus_rdata[7]}, 32'h0);
            step();
        end
        chk("R3 ready back", {31'h0, bus_rdata[7]}, 32'h1);
        rd(6'h34, v); chk("R3 scratch visible", v, 32'hA5A5_1234);

        // write while busy is dropped
        wr(6'h34, 32'h0000_0011);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'h34; bus_wdata = 32'h0000_0022;
        step();
        bus_sel = 0; bus_wr = 0;
        settle();
        rd(6'h34, v); chk("R11 busy write ignored", v, 32'h0000_0011);

        // trim and unmapped
        wr(6'h0C, 32'h0000_003C); settle();
        rd(6'h0C, v); chk("R7 trim", v, 32'h3C);
        rd(6'h10, v); chk("R1 unmapped", v, 32'h0);

        // counting with second event
        wr(6'h04, 32'd100); settle();
        rd(6'h04, v); chk("R8 load", v, 32'd100);
        wr(6'h00, 32'h21);
        tick_on = 1;
        for (int i = 0; i < 30; i++) step();
        rd(6'h00, v); chk("R9 second flag", {31'h0, v[6]}, 32'h1);
        chk("R5 irq on second", {31'h0, irq}, 32'h1);
        rd(6'h04, v); chk("R9 advanced", {31'h0, v > 32'd100}, 32'h1);
        tick_on = 0;
        wr(6'h00, 32'h61); settle();
        rd(6'h00, v); chk("R4 write one keeps", {31'h0, v[6]}, 32'h1);
        wr(6'h00, 32'h21); settle();
        rd(6'h00, v); chk("R4 write zero clears", {31'h0, v[6]}, 32'h0);
        chk("R5 irq low", {31'h0, irq}, 32'h0);

        // alarm
        rd(6'h04, s);
        wr(6'h08, s + 32'd2);
        wr(6'h00, 32'h0D);
        settle();
        tick_on = 1;
        bus_addr = 6'h04;
        for (int i = 0; i < 100; i++) begin
            step();
            if (irq) break;
        end
        chk("R10 alarm irq", {31'h0, irq}, 32'h1);
        chk("R10 alarm secs", bus_rdata, s + 32'd2);
        tick_on = 0;
        wr(6'h00, 32'h0D); settle();
        rd(6'h00, v); chk("R4 alarm flag cleared", {31'h0, v[4]}, 32'h0);

        // load clears prescaler
        tick_on = 1;
        wr(6'h04, 32'd5000);
        bus_addr = 6'h04;
        for (int i = 0; i < CYC; i++) step();
        chk("R8 loaded value", bus_rdata, 32'd5000);
        for (int i = 0; i < 4; i++) step();
        chk("R8 prescaler restarted", bus_rdata, 32'd5000);
        for (int i = 0; i < 20; i++) step();

        // disabled counter
        wr(6'h00, 32'h0); settle();
        rd(6'h04, s);
        for (int i = 0; i < 30; i++) step();
        rd(6'h04, v); chk("R9 disabled holds", v, s);
        tick_on = 0;

        // power-down request
        wr(6'h20, 32'h0); settle();
        chk("R6 zero ignored", {31'h0, hib_req}, 32'h0);
        wr(6'h20, 32'h1); settle();
        chk("R6 request set", {31'h0, hib_req}, 32'h1);
        wr(6'h20, 32'h0); settle();
        chk("R6 sticky", {31'h0, hib_req}, 32'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule